// File: doc/BRIEF.md
# Banked Control Register File

This block holds the control registers of a small 32-bit processor core. Software reaches them through a numbered index, with one combinational read port and one write port. The registers are a status word with a backup status byte, a condition bit, two banked stack pointers (one for system mode, one for user mode), two backup program counters, a second-level backup status byte and two general spare words. The live stack pointer and the condition bit are driven straight out to the datapath. The datapath can also update the live stack pointer through its own write input.

The stack-mode flag is bit 7 of the status byte. When a status write changes that flag, the block swaps the live stack pointer with the banked copies in the same clock edge. The outgoing value is parked in the register of the mode being left, and the live pointer is loaded from the register of the mode being entered. Accessing the banked pointer that belongs to the current mode goes to the live stack pointer instead, so software always sees the pointer that is actually in use.

Top module: `ctlreg_bank`

## Requirements
- R1: After reset every stored value is zero, the mode is user (`sys_mode`=0), `cond_bit`=0, `live_sp`=0, and every index reads zero.
- R2: Index 0 (status) reads as a 32-bit word. Bits 15:8 hold the backup status byte AND 0xC1. Bits 7:6 hold status byte bits 7:6. Bit 0 holds the condition bit. All other bits read zero.
- R3: A write to index 0 loads `wr_data[15:8]` into the backup status byte and `wr_data[7:0]` into the status byte, and sets the condition bit from `wr_data[0]`. `sys_mode` equals status bit 7 (1 means system mode).
- R4: A status write that changes bit 7 from 0 to 1 stores the live SP into the user SP register and loads the live SP from the interrupt SP register. A change from 1 to 0 stores the live SP into the interrupt SP register and loads the live SP from the user SP register. A status write that keeps bit 7 unchanged moves no stack pointer.
- R5: In system mode, index 2 (interrupt SP) reads and writes the live SP, and index 3 (user SP) reaches its stored register. In user mode the roles are reversed.
- R6: Index 1 reads the condition bit in bit 0, with all other bits zero. A write to it changes only the condition bit, from `wr_data[0]`.
- R7: Indices 6 and 8 (backup PCs) store all 32 bits on write and read back with bit 0 forced to zero.
- R8: Index 7 (second backup status) stores `wr_data[7:0]` and reads back that byte AND 0xC1, zero-extended.
- R9: Indices 4 and 5 are plain 32-bit storage with no side effects.
- R10: Indices 9 to 15 read as zero, and writes to them change no register.
- R11: `sp_wr_en` loads `sp_wr_data` into the live SP. In the same cycle it is dropped when a mode-changing status write occurs, and it is also dropped when a write goes to the index currently redirected to the live SP.
- R12: `live_sp` and `cond_bit` always show the current live stack pointer and condition bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_idx | input | 4 | Read index |
| rd_data | output | 32 | Read data (combinational) |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write index |
| wr_data | input | 32 | Write data |
| sp_wr_en | input | 1 | Datapath live-SP update strobe |
| sp_wr_data | input | 32 | Datapath live-SP value |
| live_sp | output | 32 | Live stack pointer |
| cond_bit | output | 1 | Condition bit |
| sys_mode | output | 1 | Stack-mode flag (1 = system) |

## Verification
Directed sequences move the mode from user to system and back. Some of these flips carry a concurrent datapath SP update, which shows whether the swap wins and whether each parked value lands in the right bank. A status write that keeps the mode unchanged must not move any pointer, and odd values written to the backup PCs check the bit-0 masking. Random traffic mixes writes to every index, including unused ones, with random datapath SP updates, and all 16 indices are read back after each cycle. This random traffic separates correct redirection in each mode from a wrong choice of bank, and a masked read view from a wrongly stored value.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int IDX_W = 4;
  localparam int MODE_BIT = 7;

  typedef enum logic [IDX_W-1:0] {
    CR_STATUS = 4'd0,
    CR_COND   = 4'd1,
    CR_ISP    = 4'd2,
    CR_USP    = 4'd3,
    CR_SPARE0 = 4'd4,
    CR_SPARE1 = 4'd5,
    CR_BPC    = 4'd6,
    CR_BBST   = 4'd7,
    CR_BBPC   = 4'd8
  } cr_idx_e;

  // Visible 16-bit view of the status word.
  function automatic logic [15:0] status_view(input logic [7:0] bst,
                                              input logic [7:0] st,
                                              input logic cond);
    status_view = {bst & 8'hC1, st[7:6], 5'b0, cond};
  endfunction

  // Visible view of the second-level backup status byte.
  function automatic logic [7:0] bbst_view(input logic [7:0] b);
    bbst_view = b & 8'hC1;
  endfunction
endpackage

// File: rtl/ctlreg_status.sv
module ctlreg_status
  import ctlreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_status,
  input  logic        wr_cond,
  input  logic [15:0] wdata,
  output logic [7:0]  st_q,
  output logic [7:0]  bst_q,
  output logic        cond_q,
  output logic        mode_q,
  output logic        swap_to_sys,
  output logic        swap_to_usr
);
  logic new_mode;
  assign new_mode    = wdata[MODE_BIT];
  assign mode_q      = st_q[MODE_BIT];
  assign swap_to_sys = wr_status && new_mode && !mode_q;
  assign swap_to_usr = wr_status && !new_mode && mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= '0;
      bst_q  <= '0;
      cond_q <= 1'b0;
    end else if (wr_status) begin
      st_q   <= wdata[7:0];
      bst_q  <= wdata[15:8];
      cond_q <= wdata[0];
    end else if (wr_cond) begin
      cond_q <= wdata[0];
    end
  end

  p_cond_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status |=> cond_q == $past(wdata[0]));
  p_cond_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cond && !wr_status) |=> ($stable(st_q) && $stable(bst_q)));
  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_status |=> $stable(mode_q));
  p_swap_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(swap_to_sys && swap_to_usr));
endmodule

// File: rtl/ctlreg_sp_bank.sv
module ctlreg_sp_bank #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swap_to_sys,
  input  logic          swap_to_usr,
  input  logic          ctl_live_we,
  input  logic          ctl_isp_we,
  input  logic          ctl_usp_we,
  input  logic [DW-1:0] wdata,
  input  logic          dp_we,
  input  logic [DW-1:0] dp_data,
  output logic [DW-1:0] live_q,
  output logic [DW-1:0] isp_q,
  output logic [DW-1:0] usp_q
);
  logic any_swap;
  assign any_swap = swap_to_sys || swap_to_usr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      isp_q  <= '0;
      usp_q  <= '0;
    end else begin
      // Live pointer: swap beats register write beats datapath update.
      if (swap_to_sys)      live_q <= isp_q;
      else if (swap_to_usr) live_q <= usp_q;
      else if (ctl_live_we) live_q <= wdata;
      else if (dp_we)       live_q <= dp_data;

      if (swap_to_usr)     isp_q <= live_q;
      else if (ctl_isp_we) isp_q <= wdata;

      if (swap_to_sys)     usp_q <= live_q;
      else if (ctl_usp_we) usp_q <= wdata;
    end
  end

  p_swap_sys_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swap_to_sys |=> (live_q == $past(isp_q) && usp_q == $past(live_q)));
  p_swap_usr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swap_to_usr |=> (live_q == $past(usp_q) && isp_q == $past(live_q)));
  p_sp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_swap && !ctl_live_we && !dp_we) |=> $stable(live_q));
  p_dp_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_we && !any_swap && !ctl_live_we) |=> live_q == $past(dp_data));
endmodule

// File: rtl/ctlreg_store.sv
module ctlreg_store
  import ctlreg_pkg::*;
#(
  parameter int DW = 32,
  parameter int NUM_SPARE = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           bpc_q,
  output logic [DW-1:0]           bbpc_q,
  output logic [7:0]              bbst_q,
  output logic [NUM_SPARE*DW-1:0] spare_q
);
  localparam int SPARE_BASE = int'(CR_SPARE0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bpc_q  <= '0;
      bbpc_q <= '0;
      bbst_q <= '0;
    end else if (wr_en) begin
      if (wr_idx == CR_BPC)  bpc_q  <= wdata;
      if (wr_idx == CR_BBPC) bbpc_q <= wdata;
      if (wr_idx == CR_BBST) bbst_q <= wdata[7:0];
    end
  end

  for (genvar g = 0; g < NUM_SPARE; g++) begin : g_spare
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(SPARE_BASE + g);
    always_ff @(posedge clk) begin
      if (!rst_n)                        spare_q[g*DW +: DW] <= '0;
      else if (wr_en && wr_idx == MY_IDX) spare_q[g*DW +: DW] <= wdata;
    end
  end

  p_bpc_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == CR_BPC) |=> bpc_q == $past(wdata));
  p_bbst_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == CR_BBST) |=> bbst_q == $past(wdata[7:0]));
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter int DW = 32,
  parameter int NUM_SPARE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       rd_idx,
  output logic [DW-1:0]    rd_data,
  input  logic             wr_en,
  input  logic [3:0]       wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             sp_wr_en,
  input  logic [DW-1:0]    sp_wr_data,
  output logic [DW-1:0]    live_sp,
  output logic             cond_bit,
  output logic             sys_mode
);
  logic [7:0]              st_q, bst_q, bbst_q;
  logic                    cond_q, mode_q, swap_to_sys, swap_to_usr;
  logic [DW-1:0]           live_q, isp_q, usp_q, bpc_q, bbpc_q;
  logic [NUM_SPARE*DW-1:0] spare_q;
  logic                    wr_status, wr_cond, ctl_live_we, ctl_isp_we, ctl_usp_we;

  assign wr_status   = wr_en && wr_idx == CR_STATUS;
  assign wr_cond     = wr_en && wr_idx == CR_COND;
  assign ctl_live_we = wr_en && ((wr_idx == CR_ISP && mode_q) ||
                                 (wr_idx == CR_USP && !mode_q));
  assign ctl_isp_we  = wr_en && wr_idx == CR_ISP && !mode_q;
  assign ctl_usp_we  = wr_en && wr_idx == CR_USP && mode_q;

  ctlreg_status u_status (
    .clk(clk), .rst_n(rst_n), .wr_status(wr_status), .wr_cond(wr_cond),
    .wdata(wr_data[15:0]), .st_q(st_q), .bst_q(bst_q), .cond_q(cond_q),
    .mode_q(mode_q), .swap_to_sys(swap_to_sys), .swap_to_usr(swap_to_usr)
  );

  ctlreg_sp_bank #(.DW(DW)) u_sp (
    .clk(clk), .rst_n(rst_n), .swap_to_sys(swap_to_sys), .swap_to_usr(swap_to_usr),
    .ctl_live_we(ctl_live_we), .ctl_isp_we(ctl_isp_we), .ctl_usp_we(ctl_usp_we),
    .wdata(wr_data), .dp_we(sp_wr_en), .dp_data(sp_wr_data),
    .live_q(live_q), .isp_q(isp_q), .usp_q(usp_q)
  );

  ctlreg_store #(.DW(DW), .NUM_SPARE(NUM_SPARE)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wdata(wr_data),
    .bpc_q(bpc_q), .bbpc_q(bbpc_q), .bbst_q(bbst_q), .spare_q(spare_q)
  );

  assign live_sp  = live_q;
  assign cond_bit = cond_q;
  assign sys_mode = mode_q;

  always_comb begin
    rd_data = '0;
    case (rd_idx)
      CR_STATUS: rd_data = DW'(status_view(bst_q, st_q, cond_q));
      CR_COND:   rd_data = DW'(cond_q);
      CR_ISP:    rd_data = mode_q ? live_q : isp_q;
      CR_USP:    rd_data = mode_q ? usp_q : live_q;
      CR_SPARE0: rd_data = spare_q[0 +: DW];
      CR_SPARE1: rd_data = spare_q[DW +: DW];
      CR_BPC:    rd_data = {bpc_q[DW-1:1], 1'b0};
      CR_BBST:   rd_data = DW'(bbst_view(bbst_q));
      CR_BBPC:   rd_data = {bbpc_q[DW-1:1], 1'b0};
      default:   rd_data = '0;
    endcase
  end

  p_pc_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == CR_BPC || rd_idx == CR_BBPC) |-> !rd_data[0]);
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx > CR_BBPC) |-> rd_data == '0);
  p_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == CR_ISP && sys_mode) |-> rd_data == live_sp);
  p_mode_from_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status |=> sys_mode == $past(wr_data[7]));
endmodule

// File: tb/ctlreg_bank_tb.sv
`timescale 1ns/1ps
module ctlreg_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        sp_wr_en = 1'b0;
  logic [31:0] sp_wr_data = '0;
  logic [31:0] live_sp;
  logic        cond_bit, sys_mode;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ctlreg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
    .live_sp(live_sp), .cond_bit(cond_bit), .sys_mode(sys_mode)
  );

  // Bench model
  logic [7:0]  m_st, m_bst, m_bbst;
  logic        m_cond;
  logic [31:0] m_live, m_isp, m_usp, m_bpc, m_bbpc, m_sp0, m_sp1;

  task automatic model_reset();
    m_st = 0; m_bst = 0; m_bbst = 0; m_cond = 0;
    m_live = 0; m_isp = 0; m_usp = 0; m_bpc = 0; m_bbpc = 0; m_sp0 = 0; m_sp1 = 0;
  endtask

  function automatic logic [31:0] exp_read(input int i);
    logic sysm;
    sysm = m_st[7];
    case (i)
      0: return ({24'b0, m_bst & 8'hC1} << 8) | {24'b0, m_st & 8'hC0} | 32'(m_cond);
      1: return 32'(m_cond);
      2: return sysm ? m_live : m_isp;
      3: return sysm ? m_usp : m_live;
      4: return m_sp0;
      5: return m_sp1;
      6: return m_bpc & 32'hFFFF_FFFE;
      7: return {24'b0, m_bbst & 8'hC1};
      8: return m_bbpc & 32'hFFFF_FFFE;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string idx_tag(input int i);
    case (i)
      0: return "R2";
      1: return "R6";
      2, 3: return "R5";
      4, 5: return "R9";
      6, 8: return "R7";
      7: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic model_step(input logic we, input logic [3:0] idx, input logic [31:0] d,
                            input logic spwe, input logic [31:0] spd);
    logic sysm, live_taken;
    logic [31:0] old_live;
    sysm = m_st[7];
    old_live = m_live;
    live_taken = 0;
    if (we) begin
      case (idx)
        4'd0: begin
          if (d[7] && !sysm) begin m_usp = old_live; m_live = m_isp; live_taken = 1; end
          if (!d[7] && sysm) begin m_isp = old_live; m_live = m_usp; live_taken = 1; end
          m_st = d[7:0]; m_bst = d[15:8]; m_cond = d[0];
        end
        4'd1: m_cond = d[0];
        4'd2: if (sysm) begin m_live = d; live_taken = 1; end else m_isp = d;
        4'd3: if (!sysm) begin m_live = d; live_taken = 1; end else m_usp = d;
        4'd4: m_sp0 = d;
        4'd5: m_sp1 = d;
        4'd6: m_bpc = d;
        4'd7: m_bbst = d[7:0];
        4'd8: m_bbpc = d;
        default: ;
      endcase
    end
    if (spwe && !live_taken) m_live = spd;
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic sweep(input string ovr);
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i);
      #0.1;
      check(ovr == "" ? idx_tag(i) : ovr, $sformatf("read idx %0d", i), rd_data, exp_read(i));
    end
    check(ovr == "" ? "R12" : ovr, "live_sp", live_sp, m_live);
    check(ovr == "" ? "R12" : ovr, "cond_bit", 32'(cond_bit), 32'(m_cond));
    check(ovr == "" ? "R3" : ovr, "sys_mode", 32'(sys_mode), 32'(m_st[7]));
  endtask

  task automatic cyc(input logic we, input logic [3:0] idx, input logic [31:0] d,
                     input logic spwe, input logic [31:0] spd, input string ovr);
    @(negedge clk);
    wr_en = we; wr_idx = idx; wr_data = d; sp_wr_en = spwe; sp_wr_data = spd;
    @(posedge clk);
    #0.1;
    model_step(we, idx, d, spwe, spd);
    sweep(ovr);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0042);
    model_reset();
    repeat (3) @(posedge clk);
    #0.1;
    sweep("R1");  // reset state
    @(negedge clk);
    rst_n = 1'b1;

    // Directed: load banks in user mode (idx3 -> live, idx2 -> stored ISP)
    cyc(1, 4'd3, 32'h1111_0000, 0, 0, "R5");
    cyc(1, 4'd2, 32'h2222_0000, 0, 0, "R5");
    // Flip user->system with concurrent datapath SP update (dropped)
    cyc(1, 4'd0, 32'h0000_FF81, 1, 32'hDEAD_BEEF, "R4");
    check("R4", "live after to-sys", live_sp, 32'h2222_0000);
    // Datapath update in system mode
    cyc(0, 4'd0, 0, 1, 32'h3333_0000, "R11");
    // Status write keeping mode: no swap, sp update applies
    cyc(1, 4'd0, 32'h0000_0080, 1, 32'h4444_0000, "R4");
    check("R11", "sp update with same-mode status", live_sp, 32'h4444_0000);
    // Flip back system->user
    cyc(1, 4'd0, 32'h0000_4041, 0, 0, "R4");
    check("R4", "live after to-usr", live_sp, 32'h1111_0000);
    // Redirected write beats datapath update
    cyc(1, 4'd3, 32'h5555_0000, 1, 32'h6666_0000, "R11");
    // Condition index only touches cond
    cyc(1, 4'd1, 32'hFFFF_FF00, 0, 0, "R6");
    // Odd backup PCs, bbst, spares, unused index
    cyc(1, 4'd6, 32'h8765_4321, 0, 0, "R7");
    cyc(1, 4'd8, 32'hFFFF_FFFF, 0, 0, "R7");
    cyc(1, 4'd7, 32'hABCD_EFFF, 0, 0, "R8");
    cyc(1, 4'd5, 32'hCAFE_F00D, 0, 0, "R9");
    cyc(1, 4'd12, 32'hFFFF_FFFF, 0, 0, "R10");

    // Constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] idx;
      int r;
      r = $urandom % 20;
      idx = (r < 16) ? 4'(r % 9) : 4'(9 + ($urandom % 7));
      cyc($urandom % 4 != 0, idx, $urandom, $urandom % 2 == 1, $urandom, "");
    end

    summary();
  end
endmodule